// File: doc/BRIEF.md
# Shared-Path PCM and DSD Interpolator

This block takes one audio channel, either as signed multi-bit PCM words or as one-bit DSD samples, and raises it to a single internal rate, producing one output word per clock. Both formats use the same datapath. Each accepted sample is first widened, with no loss, into a wide signed word with guard bits. A slot counter then sets the zero-stuffing ratio, which depends on the rate: the held sample goes into the stream once every ratio cycles, and zeros fill the other cycles. A symmetric, linear-phase FIR low-pass filter with parameterised coefficients removes the stuffing images. Its result is rounded back to the output width, and saturated if it overflows.

The lowest PCM rates first pass through one or two 2x linear-interpolation stages, each with constant group delay. The slot counter pulls samples back through those stages, so every stage runs at exactly the rate that the format needs. Changing the format code flushes all filter state and raises a settling flag for one filter length.

The source presents a sample with `in_valid` once per input period, and the block keeps it until the next one arrives. The downstream modulator takes `out_data` on every clock.

Top module: `pcmdsd_interp`

## Requirements
- R1: A PCM sample on `in_data` is read as signed two's complement and widened without loss. A lone PCM sample passed through the default filter comes back at its centre tap with exactly its input value.
- R2: In the DSD formats only bit 0 of `in_data` counts: 1 maps to +(2^(IN_W-1)-1) and 0 maps to the equal negative value. All other bits are ignored.
- R3: Format codes and stuffing ratios:
  - code 0: single-rate DSD, ratio 10.
  - code 1: double-rate DSD, ratio 5.
  - code 2: PCM at 44.1/48 kHz, two 2x stages and then ratio 160.
  - code 3: PCM at 88.2/96 kHz, one 2x stage and then ratio 160.
  - code 4: PCM at 176.4/192 kHz, ratio 160.

  Exactly one cycle in every ratio cycles carries a sample. Every other cycle carries zero.
- R4: An active 2x stage answers alternate pulls in this order: first the exact midpoint of its previous and its new sample, then the new sample itself. Two cascaded stages therefore turn a step into 1/4, 1/2, 3/4 and then full value.
- R5: Output rule:
  - Each cycle the output is the sum of h[k]·x[n-k], divided by 2^5 and rounded half upward.
  - The default coefficients are h = (-2, 0, 9, 25, 32, 25, 9, 0, -2).
  - A sample stuffed into a slot cycle first appears, weighted by h[0], two clocks later.
- R6: A filtered result beyond the OUT_W signed range is clamped to the largest or smallest representable value.
- R7: On the clock edge where `fmt_code` differs from the code in use, the block clears the delay line, the 2x stages and the held sample, and drives the output to zero. That edge also ignores `in_valid`. The first slot after the flush is the second cycle after the flush edge.
- R8: `settling` is high for exactly TAPS cycles after a flush edge and then falls.
- R9: After reset the output is zero, `settling` is low, and format code 0 is in use.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal-rate clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Strobe: capture `in_data` as the new input sample |
| in_data | input | IN_W | PCM word, or the DSD bit in bit 0 |
| fmt_code | input | 3 | Format and rate code (see R3) |
| out_data | output | OUT_W | Filtered internal-rate sample, signed |
| settling | output | 1 | High while the flushed filter refills |

## Verification
The checks depend on where a fault would surface at the output:
- A slot counter running at the wrong ratio shifts the second impulse copy by whole cycles within one ratio period, so every window compares each output cycle against a model built from the requirements.
- A 2x stage that loses its phase or rounds its midpoint changes the first two or three impulse heights of a PCM window straight away.
- An unflushed delay line leaves nonzero output in the cycle just after the flush edge.
- A wrong pre-add pairing or rounding offset shows at the asymmetric and negative taps of the very first impulse.

// File: rtl/pcmdsd_pkg.sv
package pcmdsd_pkg;

    localparam logic [2:0] FMT_DSD_1X = 3'd0;
    localparam logic [2:0] FMT_DSD_2X = 3'd1;
    localparam logic [2:0] FMT_PCM_1X = 3'd2;
    localparam logic [2:0] FMT_PCM_2X = 3'd3;
    localparam logic [2:0] FMT_PCM_4X = 3'd4;

    function automatic logic code_is_dsd(input logic [2:0] code);
        return (code == FMT_DSD_1X) || (code == FMT_DSD_2X);
    endfunction

    // number of 2x interpolation stages ahead of the stuffer
    function automatic int unsigned code_x2_count(input logic [2:0] code);
        case (code)
            FMT_PCM_1X: return 2;
            FMT_PCM_2X: return 1;
            default:    return 0;
        endcase
    endfunction

endpackage

// File: rtl/sample_widen.sv
module sample_widen #(
    parameter int IN_W  = 24,
    parameter int GUARD = 4,
    localparam int W_INT = IN_W + GUARD
) (
    input  logic [IN_W-1:0]         raw,
    input  logic                    dsd_mode,
    output logic signed [W_INT-1:0] wide
);
    localparam logic signed [W_INT-1:0] FS_WIDE =
        $signed({1'b0, {(IN_W-1){1'b1}}, {GUARD{1'b0}}});

    always_comb begin
        if (dsd_mode) begin
            wide = raw[0] ? FS_WIDE : -FS_WIDE;
        end else begin
            wide = $signed({raw, {GUARD{1'b0}}});
        end
    end
endmodule

// File: rtl/interp_x2_stage.sv
module interp_x2_stage #(
    parameter int W = 28
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear,
    input  logic                active,
    input  logic                pull,
    input  logic signed [W-1:0] up_data,
    output logic                up_pull,
    output logic signed [W-1:0] out_data
);
    typedef struct packed {
        logic signed [W-1:0] cur;
        logic                odd;
    } st_t;

    st_t st_q, st_d;
    logic signed [W:0] sum;

    always_comb begin
        st_d     = st_q;
        sum      = $signed({st_q.cur[W-1], st_q.cur}) + $signed({up_data[W-1], up_data});
        out_data = up_data;
        up_pull  = pull;
        if (active) begin
            if (!st_q.odd) begin
                out_data = sum[W:1];
                up_pull  = pull;
                if (pull) begin
                    st_d.cur = up_data;
                    st_d.odd = 1'b1;
                end
            end else begin
                out_data = st_q.cur;
                up_pull  = 1'b0;
                if (pull) begin
                    st_d.odd = 1'b0;
                end
            end
        end
        if (clear) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R4: the interpolated value lies between the two samples it joins
    a_r4_midpoint_between: assert property (@(posedge clk) disable iff (!rst_n)
        (active && pull && !st_q.odd) |->
            (((out_data >= st_q.cur) && (out_data <= up_data)) ||
             ((out_data <= st_q.cur) && (out_data >= up_data))));
endmodule

// File: rtl/sym_fir.sv
module sym_fir #(
    parameter int W         = 28,
    parameter int OUT_W     = 24,
    parameter int TAPS      = 9,
    parameter int COEF_W    = 8,
    parameter int SHIFT     = 9,
    parameter logic signed [COEF_W-1:0] COEF [TAPS] =
        '{-8'sd2, 8'sd0, 8'sd9, 8'sd25, 8'sd32, 8'sd25, 8'sd9, 8'sd0, -8'sd2}
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clear,
    input  logic signed [W-1:0]     din,
    output logic signed [OUT_W-1:0] dout
);
    localparam int HALF  = TAPS / 2;
    localparam int ACC_W = W + 1 + COEF_W + $clog2(TAPS) + 1;
    localparam logic signed [ACC_W-1:0] RND  = ACC_W'(1) <<< (SHIFT - 1);
    localparam logic signed [ACC_W-1:0] MAXV =
        $signed({{(ACC_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}});
    localparam logic signed [ACC_W-1:0] MINV = -MAXV - 1;

    typedef struct packed {
        logic [TAPS-1:0][W-1:0] dl;
        logic [OUT_W-1:0]       y;
    } st_t;

    st_t st_q, st_d;
    logic signed [W:0]       pair;
    logic signed [ACC_W-1:0] ext_p, ext_c, acc, rnd, shv, sat;
    logic                    line_zero;

    always_comb begin
        acc = '0;
        for (int k = 0; k < HALF; k++) begin
            pair  = $signed(st_q.dl[k]) + $signed(st_q.dl[TAPS-1-k]);
            ext_p = pair;
            ext_c = COEF[k];
            acc   = acc + ext_p * ext_c;
        end
        ext_p = $signed(st_q.dl[HALF]);
        ext_c = COEF[HALF];
        acc   = acc + ext_p * ext_c;
        pair  = '0;
        rnd   = acc + RND;
        shv   = rnd >>> SHIFT;
        if (shv > MAXV) begin
            sat = MAXV;
        end else if (shv < MINV) begin
            sat = MINV;
        end else begin
            sat = shv;
        end
        st_d.dl = {st_q.dl[TAPS-2:0], din};
        st_d.y  = sat[OUT_W-1:0];
        if (clear) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dout      = $signed(st_q.y);
    assign line_zero = (st_q.dl == '0);

    // R5: an empty delay line yields exactly zero on the next output
    a_r5_quiet_line: assert property (@(posedge clk) disable iff (!rst_n)
        line_zero |=> (dout == '0));
endmodule

// File: rtl/pcmdsd_interp.sv
module pcmdsd_interp #(
    parameter int IN_W      = 24,
    parameter int GUARD     = 4,
    parameter int OUT_W     = 24,
    parameter int TAPS      = 9,
    parameter int COEF_W    = 8,
    parameter int COEF_FRAC = 5,
    parameter logic signed [COEF_W-1:0] COEF [TAPS] =
        '{-8'sd2, 8'sd0, 8'sd9, 8'sd25, 8'sd32, 8'sd25, 8'sd9, 8'sd0, -8'sd2},
    parameter int R_DSD1    = 10,
    parameter int R_DSD2    = 5,
    parameter int R_PCM     = 160,
    parameter int NUM_X2    = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [IN_W-1:0]         in_data,
    input  logic [2:0]              fmt_code,
    output logic signed [OUT_W-1:0] out_data,
    output logic                    settling
);
    import pcmdsd_pkg::*;

    localparam int W_INT = IN_W + GUARD;
    localparam int R_MAX = (R_PCM > R_DSD1) ? ((R_PCM > R_DSD2) ? R_PCM : R_DSD2)
                                            : ((R_DSD1 > R_DSD2) ? R_DSD1 : R_DSD2);
    localparam int PH_W  = $clog2(R_MAX);
    localparam int CNT_W = $clog2(TAPS + 1);

    typedef struct packed {
        logic [2:0]             fmt;
        logic [W_INT-1:0]       hold;
        logic [PH_W-1:0]        phase;
        logic [CNT_W-1:0]       settle;
    } st_t;

    st_t st_q, st_d;

    logic                    change;
    logic                    slot;
    logic signed [W_INT-1:0] widened;
    logic signed [W_INT-1:0] stuffed;
    logic [PH_W-1:0]         ratio_q;
    int unsigned             n_x2;

    logic signed [W_INT-1:0] chain_data [NUM_X2+1];
    logic                    chain_pull [NUM_X2+1];

    function automatic logic [PH_W-1:0] ratio_of(input logic [2:0] code);
        case (code)
            FMT_DSD_1X: return PH_W'(R_DSD1);
            FMT_DSD_2X: return PH_W'(R_DSD2);
            default:    return PH_W'(R_PCM);
        endcase
    endfunction

    sample_widen #(.IN_W(IN_W), .GUARD(GUARD)) u_widen (
        .raw      (in_data),
        .dsd_mode (code_is_dsd(st_q.fmt)),
        .wide     (widened)
    );

    assign ratio_q       = ratio_of(st_q.fmt);
    assign n_x2          = code_x2_count(st_q.fmt);
    assign change        = (fmt_code != st_q.fmt);
    assign slot          = (st_q.phase == '0) && !change;
    assign chain_data[0] = $signed(st_q.hold);
    assign chain_pull[NUM_X2] = slot;

    for (genvar i = 0; i < NUM_X2; i++) begin : g_x2
        logic stage_on;
        assign stage_on = (i + int'(n_x2)) >= NUM_X2;
        interp_x2_stage #(.W(W_INT)) u_stage (
            .clk      (clk),
            .rst_n    (rst_n),
            .clear    (change),
            .active   (stage_on),
            .pull     (chain_pull[i+1]),
            .up_data  (chain_data[i]),
            .up_pull  (chain_pull[i]),
            .out_data (chain_data[i+1])
        );
    end

    assign stuffed = slot ? chain_data[NUM_X2] : '0;

    always_comb begin
        st_d = st_q;
        if (change) begin
            st_d.fmt    = fmt_code;
            st_d.hold   = '0;
            st_d.phase  = ratio_of(fmt_code) - PH_W'(1);
            st_d.settle = CNT_W'(TAPS);
        end else begin
            if (in_valid) begin
                st_d.hold = widened;
            end
            if (st_q.phase >= ratio_q - PH_W'(1)) begin
                st_d.phase = '0;
            end else begin
                st_d.phase = st_q.phase + PH_W'(1);
            end
            if (st_q.settle != '0) begin
                st_d.settle = st_q.settle - CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    sym_fir #(
        .W      (W_INT),
        .OUT_W  (OUT_W),
        .TAPS   (TAPS),
        .COEF_W (COEF_W),
        .SHIFT  (COEF_FRAC + GUARD),
        .COEF   (COEF)
    ) u_fir (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (change),
        .din   (stuffed),
        .dout  (out_data)
    );

    assign settling = (st_q.settle != '0);

    // R7: the edge that sees a new code leaves a silent, settling block
    a_r7_flush_clear: assert property (@(posedge clk) disable iff (!rst_n)
        change |=> (settling && (out_data == '0)));

    // R8: settling only starts from a format change
    a_r8_settle_origin: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(settling) |-> $past(change));

    // R3: the held input is consumed only in a slot cycle
    a_r3_source_pull: assert property (@(posedge clk) disable iff (!rst_n)
        chain_pull[0] |-> (st_q.phase == '0));
endmodule

// File: tb/pcmdsd_interp_bench.sv
module pcmdsd_interp_bench;
    localparam int CLK_PERIOD = 10;
    localparam int TAPS       = 9;
    localparam longint FS16   = 64'd8388607 * 16;
    localparam int H [TAPS]   = '{-2, 0, 9, 25, 32, 25, 9, 0, -2};

    localparam int NV = 7;
    localparam logic [2:0]  V_FMT  [NV] = '{3'd0, 3'd0, 3'd1, 3'd4, 3'd4, 3'd3, 3'd2};
    localparam logic [23:0] V_DATA [NV] = '{24'h000001, 24'hFFFFFE, 24'h000001,
                                            24'd1000, 24'hFFFC18, 24'd4096, 24'hFFF060};
    localparam int          V_PEAK [NV] = '{8388607, -8388607, 8388607,
                                            1000, -1000, 2048, -1000};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [23:0] in_data = '0;
    logic [2:0]  fmt_code = '0;
    logic signed [23:0] out_data, out_hot;
    logic        settling, settling_hot;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pcmdsd_interp u_pcmdsd_interp (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .fmt_code(fmt_code), .out_data(out_data), .settling(settling)
    );

    pcmdsd_interp #(.COEF('{8'sd0, 8'sd0, 8'sd0, 8'sd0, 8'sd48, 8'sd0, 8'sd0, 8'sd0, 8'sd0}))
    u_pcmdsd_interp_hot (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .fmt_code(fmt_code), .out_data(out_hot), .settling(settling_hot)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int ratio(input logic [2:0] f);
        return (f == 3'd0) ? 10 : (f == 3'd1) ? 5 : 160;
    endfunction

    function automatic longint amp(input logic [2:0] f, input logic [23:0] d, input int s);
        longint w;
        int ns;
        if (f <= 3'd1) w = d[0] ? FS16 : -FS16;
        else           w = longint'($signed(d)) * 16;
        ns = (f == 3'd2) ? 2 : (f == 3'd3) ? 1 : 0;
        if (ns == 1 && s == 0) return w / 2;
        if (ns == 2 && s == 0) return w / 4;
        if (ns == 2 && s == 1) return w / 2;
        if (ns == 2 && s == 2) return (3 * w) / 4;
        return w;
    endfunction

    function automatic longint expect_out(input logic [2:0] f, input logic [23:0] d, input int n);
        longint acc = 0;
        longint r;
        int rr = ratio(f);
        for (int k = 0; k < TAPS; k++) begin
            int m = n - 3 - k;
            if (m >= 0 && (m % rr) == 0) acc += H[k] * amp(f, d, m / rr);
        end
        r = (acc + 256) >>> 9;
        if (r > 8388607)  r = 8388607;
        if (r < -8388608) r = -8388608;
        return r;
    endfunction

    // flush into format f, load sample d; returns at the negedge after edge 1
    task automatic start(input logic [2:0] f, input logic [23:0] d);
        @(negedge clk);
        fmt_code = 3'd7;
        in_valid = 1'b0;
        @(negedge clk);
        fmt_code = f;
        @(posedge clk);
        @(negedge clk);
        chk("R7 output cleared at flush", longint'(out_data), 0);
        chk("R8 settling raised at flush", longint'(settling), 1);
        in_valid = 1'b1;
        in_data  = d;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 reset output", longint'(out_data), 0);
        chk("R9 reset settling", longint'(settling), 0);

        // table walk: R1 R2 R3 R4 R5 per vector
        for (int v = 0; v < NV; v++) begin
            int nmax = 3 + 3 * ratio(V_FMT[v]) + TAPS;
            start(V_FMT[v], V_DATA[v]);
            for (int n = 1; n <= nmax; n++) begin
                chk($sformatf("R3/R5 vec%0d cycle%0d", v, n), longint'(out_data),
                    expect_out(V_FMT[v], V_DATA[v], n));
                if (n == 7)
                    chk($sformatf("R1/R2/R4 vec%0d peak", v), longint'(out_data),
                        longint'(V_PEAK[v]));
                if (n == TAPS - 1) chk("R8 settling held", longint'(settling), 1);
                if (n == TAPS)     chk("R8 settling dropped", longint'(settling), 0);
                @(negedge clk);
            end
        end

        // R6 positive clamp
        start(3'd4, 24'h7FFFFF);
        for (int n = 1; n <= 7; n++) begin
            if (n == 7) begin
                chk("R6 positive clamp", longint'(out_hot), 8388607);
                chk("R1 full scale exact", longint'(out_data), 8388607);
            end
            @(negedge clk);
        end

        // R6 negative clamp
        start(3'd4, -24'sd6000000);
        for (int n = 1; n <= 7; n++) begin
            if (n == 7) chk("R6 negative clamp", longint'(out_hot), -8388608);
            @(negedge clk);
        end

        // R7: a flush mid-stream erases pending state
        start(3'd0, 24'h000001);
        repeat (4) @(negedge clk);
        fmt_code = 3'd1;
        @(posedge clk);
        @(negedge clk);
        chk("R7 mid-stream flush silent", longint'(out_data), 0);
        repeat (6) @(negedge clk);
        chk("R7 held sample cleared", longint'(out_data), 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule